// File: doc/BRIEF.md
# Latched Parallel Channel Decoder for a Four-Way Switch Matrix

This block turns a small parallel control bus into the on/off controls of four routing switches that feed two common nodes. The controls are a two-bit channel address, a switch enable, a load strobe, an active-low reset and a configuration pin. The address and the enable pass through a holding stage. That stage follows its inputs while the strobe is low and freezes them while the strobe is high, so a host can set up a new selection and then lock it in.

The configuration pin is not held. It picks how the held address is decoded. In one setting the four switches form a single 1-of-4 selector. In the other they form two independent 1-of-2 selectors that move together. Whenever the switch pattern changes from one non-empty set to another, the outputs first pass through one clock cycle with every switch open. The holding stage is built from flops running on a free-running system clock.

Top module: `mux_chan_dec`

## Requirements
- R1: While reset is low, and afterwards until a new selection is loaded, every switch is open (`sw_on` = 4'b0000). The held address and enable are cleared to zero, so an input enable of 1 presented only while the strobe is high leaves all switches open.
- R2: While `load_hold` is low, the address and enable are captured on every rising clock edge.
- R3: While `load_hold` is high, the held address and enable do not change, and any change on `chan_sel` or `sw_enable` has no effect on `sw_on`.
- R4: `pair_mode` bypasses the holding stage. A change on it alters the decode of the held address even while `load_hold` is high.
- R5: A held enable of 0 opens every switch, whatever the address and mode.
- R6: With `pair_mode` low and the enable held at 1, held address value k (0 to 3) closes only switch k, which is `sw_on[k]`.
- R7: With `pair_mode` high and the enable held at 1, `chan_sel[1]` is ignored. Address bit 0 equal to 0 gives `sw_on` = 4'b0101, and equal to 1 gives 4'b1010.
- R8: When the decoded pattern changes from one non-zero value to a different non-zero value, `sw_on` is 4'b0000 for exactly one cycle before the new pattern appears. Two different non-zero patterns are never output on consecutive cycles.
- R9: Timing of the outputs. Inputs captured at clock edge E reach `sw_on` at edge E+1 when the switches were open, or at edge E+2 after the R8 gap. Driving `rst_n` low opens every switch at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| rst_n | input | 1 | Active-low reset: asserts asynchronously, releases synchronously |
| chan_sel | input | 2 | Channel address; bit 1 is the more significant bit |
| sw_enable | input | 1 | Switch enable, held with the address |
| load_hold | input | 1 | Low: capture the inputs each cycle; high: hold the last captured values |
| pair_mode | input | 1 | 0: one 1-of-4 selector; 1: two 1-of-2 selectors; not held |
| sw_on | output | 4 | Switch closed controls; bit k drives switch k |

## Verification
An address or enable sampled at a rising edge reaches the holding stage at that same edge. It shows on `sw_on` one edge later if all switches were open, or two edges later when the break cycle comes first. A change on the configuration pin follows the same one- or two-edge path from the next edge. The bench drives every input on falling edges and reads `sw_on` on the falling edges that follow. For each sweep point it waits four edges so that both latencies have settled. The break cycle is checked edge by edge: the old pattern, then all open, then the new pattern. Reset is checked a fraction of a cycle after it falls, before any further edge.

// File: rtl/mdec_pkg.sv
package mdec_pkg;
  localparam int SW_N   = 4;
  localparam int ADDR_W = $clog2(SW_N);

  typedef enum logic {
    MODE_QUAD = 1'b0,
    MODE_PAIR = 1'b1
  } mode_e;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic              en;
  } sel_t;
endpackage

// File: rtl/mdec_hold.sv
module mdec_hold
  import mdec_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  sel_t sel_in,
  input  logic hold,
  output sel_t sel_q
);
  logic ld;
  sel_t sel_d;

  assign ld = ~hold;

  always_comb begin
    sel_d = sel_q;
    if (ld) sel_d = sel_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_q <= '0;
    else        sel_q <= sel_d;
  end

  // R3
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> $stable(sel_q));

  // R2
  follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hold |=> sel_q == $past(sel_in));
endmodule

// File: rtl/mdec_decode.sv
module mdec_decode
  import mdec_pkg::*;
(
  input  sel_t            sel,
  input  mode_e           mode,
  output logic [SW_N-1:0] tgt
);
  for (genvar i = 0; i < SW_N; i++) begin : g_sw
    localparam logic [ADDR_W-1:0] IDX = ADDR_W'(i);
    localparam logic              ODD = 1'(i % 2);
    logic quad_hit, pair_hit;
    assign quad_hit = (sel.addr == IDX);
    assign pair_hit = (sel.addr[0] == ODD);
    assign tgt[i]   = sel.en & ((mode == MODE_PAIR) ? pair_hit : quad_hit);
  end

  // R6
  always_comb quad_onehot_chk: assert ((mode != MODE_QUAD) || $onehot0(tgt));

  // R7
  always_comb pair_count_chk: assert ((mode != MODE_PAIR) || !sel.en ||
                                      ($countones(tgt) == 2));
endmodule

// File: rtl/mdec_bbm.sv
module mdec_bbm
  import mdec_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [SW_N-1:0] tgt,
  output logic [SW_N-1:0] sw_q
);
  logic [SW_N-1:0] sw_d;
  logic            chg;

  assign chg = (tgt != sw_q);

  always_comb begin
    sw_d = sw_q;
    if (chg) sw_d = (sw_q != '0) ? '0 : tgt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   sw_q <= '0;
    else if (chg) sw_q <= sw_d;
  end

  // R8
  bbm_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_q != '0 && $past(sw_q) != '0) |-> sw_q == $past(sw_q));
endmodule

// File: rtl/mux_chan_dec.sv
module mux_chan_dec
  import mdec_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ADDR_W-1:0] chan_sel,
  input  logic             sw_enable,
  input  logic             load_hold,
  input  logic             pair_mode,
  output logic [SW_N-1:0]  sw_on
);
  logic [1:0]      rst_pipe;
  logic            rst_i_n;
  sel_t            sel_in, sel_q;
  logic [SW_N-1:0] tgt;
  mode_e           mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_i_n = rst_pipe[1];

  assign sel_in = '{addr: chan_sel, en: sw_enable};
  assign mode   = mode_e'(pair_mode);

  mdec_hold u_hold (
    .clk   (clk),
    .rst_n (rst_i_n),
    .sel_in(sel_in),
    .hold  (load_hold),
    .sel_q (sel_q)
  );

  mdec_decode u_dec (
    .sel (sel_q),
    .mode(mode),
    .tgt (tgt)
  );

  mdec_bbm u_bbm (
    .clk  (clk),
    .rst_n(rst_i_n),
    .tgt  (tgt),
    .sw_q (sw_on)
  );

  // R1
  reset_open_chk: assert property (@(posedge clk)
    !rst_n |-> sw_on == '0);

  // R5
  en_off_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    !sel_q.en |=> sw_on == '0);
endmodule

// File: tb/mux_chan_dec_test.sv
module mux_chan_dec_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] chan_sel;
  logic       sw_enable, load_hold, pair_mode;
  logic [3:0] sw_on;
  int         total = 0, bad = 0;
  bit         done = 0;

  mux_chan_dec uut (
    .clk(clk), .rst_n(rst_n), .chan_sel(chan_sel), .sw_enable(sw_enable),
    .load_hold(load_hold), .pair_mode(pair_mode), .sw_on(sw_on)
  );

  always #2 clk = ~clk;

  task automatic check(input string req, input logic [3:0] exp);
    total++;
    if (sw_on !== exp) begin
      bad++;
      $display("FAIL %s: sw_on=%b expected=%b", req, sw_on, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [3:0] model(input logic pm, input logic en,
                                       input logic [1:0] a);
    if (!en) return 4'b0000;
    if (pm)  return a[0] ? 4'b1010 : 4'b0101;
    return 4'(1 << a);
  endfunction

  initial begin
    rst_n = 1'b0; chan_sel = 2'd0; sw_enable = 1'b0;
    load_hold = 1'b1; pair_mode = 1'b0;
    edges(3);
    check("R1 during reset", 4'b0000);
    rst_n = 1'b1;
    edges(3);
    chan_sel = 2'd3; sw_enable = 1'b1;  // strobe still high
    edges(4);
    check("R1 cleared hold keeps switches open", 4'b0000);

    // R5 R6 R7 sweep
    load_hold = 1'b0;
    for (int pm = 0; pm < 2; pm++)
      for (int en = 0; en < 2; en++)
        for (int a = 0; a < 4; a++) begin
          pair_mode = pm[0]; sw_enable = en[0]; chan_sel = a[1:0];
          edges(4);
          check(pm ? (en ? "R7 pair decode" : "R5 enable off pair")
                   : (en ? "R6 quad decode" : "R5 enable off quad"),
                model(pm[0], en[0], a[1:0]));
        end

    // R8 R9 break-before-make, edge by edge
    pair_mode = 1'b0; sw_enable = 1'b1; chan_sel = 2'd0;
    edges(4);
    check("R6 settle addr0", 4'b0001);
    chan_sel = 2'd1;
    edges(1);
    check("R9 old pattern after capture edge", 4'b0001);
    edges(1);
    check("R8 break cycle", 4'b0000);
    edges(1);
    check("R9 new pattern second edge", 4'b0010);

    // R9 from open: one edge
    sw_enable = 1'b0; edges(4);
    sw_enable = 1'b1; chan_sel = 2'd2;
    edges(1);
    check("R9 open before update", 4'b0000);
    edges(1);
    check("R9 from open one edge", 4'b0100);

    // R3 hold
    load_hold = 1'b1;
    chan_sel = 2'd1; sw_enable = 1'b0;
    edges(4);
    check("R3 inputs ignored while held", 4'b0100);

    // R4 mode bypasses hold (held addr 2 -> bit0 = 0)
    pair_mode = 1'b1;
    edges(4);
    check("R4 mode change while held", 4'b0101);

    // R2 release strobe
    load_hold = 1'b0; pair_mode = 1'b0; chan_sel = 2'd3; sw_enable = 1'b1;
    edges(4);
    check("R2 capture after release", 4'b1000);

    // R9 async reset
    #1 rst_n = 1'b0;
    #0.5;
    check("R9 async reset opens switches", 4'b0000);
    edges(2);
    rst_n = 1'b1;
    edges(4);
    check("R1 after reset release", 4'b1000 & 4'b0000 | model(1'b0, 1'b1, 2'd3));

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: expired expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule